// File: doc/BRIEF.md
# Square Channel Period Sweep

This block owns the 11-bit period register of a square-wave tone channel and moves that period on a slow, regular schedule. On each scheduled update it takes the period, shifts a copy of it right by a programmable amount, and then adds that copy to the period or subtracts it. The pitch therefore glides down or up. Software may overwrite the period at any time through two byte-wide write strobes, and the glide then continues from the value just written.

The block also produces a mute flag. The flag is raised when the period is too short to be audible, or when an upward step would overflow the 11-bit range. Both conditions apply even while sweeping is switched off. When the flag is raised, sweep updates are blocked. A build-time parameter selects one of two channel variants. The variants differ only in how a downward step is subtracted: one takes an extra count off (one's complement), and the other subtracts exactly (two's complement).

Top module: `sq_sweep`

## Requirements
- R1: After an asynchronous reset the period reads 0, the mute flag is high because the period is below 8, and the update divider is cleared.
- R2: A write on the low strobe loads period bits 7:0 from data bits 7:0. A write on the high strobe loads period bits 10:8 from data bits 2:0. The new value appears on the period output in the cycle after the write.
- R3: Control byte layout: bit 7 enables sweeping, bits 6:4 are the rate N, bit 3 selects decrease (1) or increase (0), and bits 2:0 are the shift S. In increase mode an update sets the period to P + (P >> S).
- R4: In decrease mode an update sets the period to P - (P >> S) - 1 when SUB_TWOS = 0, and to P - (P >> S) when SUB_TWOS = 1.
- R5: A scheduled update leaves the period unchanged when sweeping is disabled, when the shift is 0, or when the length-nonzero input is low.
- R6: Whenever the period is below 8, the mute flag is high and updates are blocked, whether or not sweeping is enabled.
- R7: In increase mode, a carry out of bit 10 of P + (P >> S) raises the mute flag and blocks updates, whether or not sweeping is enabled. In decrease mode no carry mute applies.
- R8: Updates occur on one half-frame tick in N+1. The first tick after reset is an update tick, because the divider starts at 0 and reloads with N each time it fires.
- R9: After a software write, the next update starts from the written period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | Half-frame tick, one cycle wide |
| ctrl_i | input | 8 | Sweep control byte |
| per_lo_we_i | input | 1 | Write strobe for period bits 7:0 |
| per_hi_we_i | input | 1 | Write strobe for period bits 10:8 |
| per_data_i | input | 8 | Write data for the period strobes |
| len_nz_i | input | 1 | High while the channel length count is nonzero |
| period_o | output | 11 | Current period |
| mute_o | output | 1 | Channel must be silenced |

## Verification
The bench builds two instances side by side on the same stimulus, one with SUB_TWOS = 0 and one with SUB_TWOS = 1. This puts the extra-count subtraction and the exact subtraction in reach within a single decrease scenario, with values that differ by exactly one. Every other behaviour must match between the two instances, so each check on the shared paths (writes, gating, both mute causes, rate division) is made against both variants.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int unsigned PER_W   = 11;
  localparam int unsigned RATE_W  = 3;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned CTRL_W  = 2 + RATE_W + SHIFT_W;
  localparam int unsigned PER_HI_W = PER_W - 8;

  typedef struct packed {
    logic               en;
    logic [RATE_W-1:0]  rate;
    logic               dec;
    logic [SHIFT_W-1:0] shift;
  } sweep_ctrl_t;
endpackage

// File: rtl/sweep_rate_div.sv
module sweep_rate_div
  import sweep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              fire_o
);
  logic [RATE_W-1:0] div_q;

  assign fire_o = tick_i && (div_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (tick_i) div_q <= (div_q == '0) ? rate_i : div_q - 1'b1;
  end
endmodule

// File: rtl/sweep_target_calc.sv
module sweep_target_calc
  import sweep_pkg::*;
#(
  parameter bit SUB_TWOS = 1'b0
) (
  input  logic [PER_W-1:0]   per_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               dec_i,
  output logic [PER_W-1:0]   next_o,
  output logic               carry_o
);
  logic [PER_W-1:0] delta;
  logic [PER_W:0]   sum;
  logic [PER_W-1:0] diff;

  assign delta = per_i >> shift_i;
  assign sum   = {1'b0, per_i} + {1'b0, delta};

  generate
    if (SUB_TWOS) begin : g_twos
      assign diff = per_i - delta;
    end else begin : g_ones
      assign diff = per_i + ~delta;
    end
  endgenerate

  assign carry_o = !dec_i && sum[PER_W];
  assign next_o  = dec_i ? diff : sum[PER_W-1:0];
endmodule

// File: rtl/sq_sweep.sv
module sq_sweep
  import sweep_pkg::*;
#(
  parameter bit          SUB_TWOS = 1'b0,
  parameter int unsigned MIN_PER  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_tick_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              per_lo_we_i,
  input  logic              per_hi_we_i,
  input  logic [7:0]        per_data_i,
  input  logic              len_nz_i,
  output logic [PER_W-1:0]  period_o,
  output logic              mute_o
);
  sweep_ctrl_t      ctrl;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] per_next;
  logic             carry;
  logic             fire;
  logic             too_short;
  logic             do_update;

  assign ctrl = sweep_ctrl_t'(ctrl_i);

  sweep_rate_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (half_tick_i),
    .rate_i (ctrl.rate),
    .fire_o (fire)
  );

  sweep_target_calc #(.SUB_TWOS(SUB_TWOS)) u_calc (
    .per_i   (per_q),
    .shift_i (ctrl.shift),
    .dec_i   (ctrl.dec),
    .next_o  (per_next),
    .carry_o (carry)
  );

  assign too_short = per_q < PER_W'(MIN_PER);
  assign mute_o    = too_short || carry;
  assign do_update = fire && ctrl.en && (ctrl.shift != '0) && len_nz_i && !mute_o;

  // software writes win over a coincident sweep update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
    end else if (per_lo_we_i || per_hi_we_i) begin
      if (per_lo_we_i) per_q[7:0]     <= per_data_i;
      if (per_hi_we_i) per_q[PER_W-1:8] <= per_data_i[PER_HI_W-1:0];
    end else if (do_update) begin
      per_q <= per_next;
    end
  end

  assign period_o = per_q;
endmodule

// File: rtl/sq_sweep_chk.sv
module sq_sweep_chk
  import sweep_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              per_lo_we_i,
  input logic              per_hi_we_i,
  input logic [7:0]        per_data_i,
  input logic              len_nz_i,
  input logic [PER_W-1:0]  period_o,
  input logic              mute_o
);
  logic no_wr;
  assign no_wr = !per_lo_we_i && !per_hi_we_i;

  // R2
  lo_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_lo_we_i |=> period_o[7:0] == $past(per_data_i));

  // R2
  hi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_hi_we_i |=> period_o[PER_W-1:8] == $past(per_data_i[PER_HI_W-1:0]));

  // R3
  inc_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_wr && !ctrl_i[3]) |=> period_o >= $past(period_o));

  // R4
  dec_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_wr && ctrl_i[3]) |=> period_o <= $past(period_o));

  // R5
  gated_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_wr && (!ctrl_i[7] || ctrl_i[2:0] == '0 || !len_nz_i)) |=> $stable(period_o));

  // R6
  short_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_wr && period_o < PER_W'(8)) |=> $stable(period_o) && mute_o);

  // R7
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_wr && mute_o && !ctrl_i[3]) |=> $stable(period_o));
endmodule

bind sq_sweep sq_sweep_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_i      (ctrl_i),
  .per_lo_we_i (per_lo_we_i),
  .per_hi_we_i (per_hi_we_i),
  .per_data_i  (per_data_i),
  .len_nz_i    (len_nz_i),
  .period_o    (period_o),
  .mute_o      (mute_o)
);

// File: tb/tb_sq_sweep.sv
module tb_sq_sweep;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  ctrl = '0;
  logic        we_lo = 1'b0;
  logic        we_hi = 1'b0;
  logic [7:0]  wdata = '0;
  logic        len_nz = 1'b1;
  logic [10:0] per_a, per_b;
  logic        mute_a, mute_b;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sq_sweep #(.SUB_TWOS(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .half_tick_i(tick), .ctrl_i(ctrl),
    .per_lo_we_i(we_lo), .per_hi_we_i(we_hi), .per_data_i(wdata),
    .len_nz_i(len_nz), .period_o(per_a), .mute_o(mute_a));

  sq_sweep #(.SUB_TWOS(1'b1)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .half_tick_i(tick), .ctrl_i(ctrl),
    .per_lo_we_i(we_lo), .per_hi_we_i(we_hi), .per_data_i(wdata),
    .len_nz_i(len_nz), .period_o(per_b), .mute_o(mute_b));

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic chk_both(input string req, input int exp_a, input int exp_b,
                          input bit exp_mute);
    check({req, " period v0"}, per_a, exp_a);
    check({req, " period v1"}, per_b, exp_b);
    check({req, " mute v0"}, mute_a, exp_mute);
    check({req, " mute v1"}, mute_b, exp_mute);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; we_lo = 1'b0; we_hi = 1'b0; ctrl = '0; len_nz = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_per(input logic [10:0] p);
    we_lo = 1'b1; wdata = p[7:0];
    @(negedge clk);
    we_lo = 1'b0; we_hi = 1'b1; wdata = {5'b0, p[10:8]};
    @(negedge clk);
    we_hi = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_both("R1 reset", 0, 0, 1'b1);
  endtask

  task automatic t_write();
    do_reset();
    we_lo = 1'b1; wdata = 8'h23;
    @(negedge clk);
    we_lo = 1'b0;
    check("R2 low byte v0", per_a, 11'h023);
    we_hi = 1'b1; wdata = 8'hF9;
    @(negedge clk);
    we_hi = 1'b0;
    chk_both("R2 high bits", 11'h123, 11'h123, 1'b0);
  endtask

  task automatic t_increase();
    do_reset();
    write_per(11'h100);
    ctrl = 8'h82;
    pulse_tick();
    chk_both("R3 inc step1", 11'h140, 11'h140, 1'b0);
    pulse_tick();
    chk_both("R3 inc step2", 11'h190, 11'h190, 1'b0);
    write_per(11'h200);
    pulse_tick();
    chk_both("R9 sweep from written", 11'h280, 11'h280, 1'b0);
  endtask

  task automatic t_decrease();
    do_reset();
    write_per(11'h100);
    ctrl = 8'h89;
    pulse_tick();
    chk_both("R4 dec step1", 11'h07F, 11'h080, 1'b0);
    pulse_tick();
    chk_both("R4 dec step2", 11'h03F, 11'h040, 1'b0);
  endtask

  task automatic t_gating();
    do_reset();
    write_per(11'h100);
    ctrl = 8'h02;
    pulse_tick();
    chk_both("R5 disabled", 11'h100, 11'h100, 1'b0);
    ctrl = 8'h80;
    pulse_tick();
    chk_both("R5 shift zero", 11'h100, 11'h100, 1'b0);
    ctrl = 8'h82; len_nz = 1'b0;
    pulse_tick();
    chk_both("R5 length zero", 11'h100, 11'h100, 1'b0);
    len_nz = 1'b1;
    pulse_tick();
    chk_both("R5 all open", 11'h140, 11'h140, 1'b0);
  endtask

  task automatic t_short();
    do_reset();
    write_per(11'h007);
    ctrl = 8'h00;
    @(negedge clk);
    chk_both("R6 short disabled", 11'h007, 11'h007, 1'b1);
    ctrl = 8'h89;
    pulse_tick();
    chk_both("R6 short blocked", 11'h007, 11'h007, 1'b1);
    write_per(11'h008);
    chk_both("R6 boundary 8", 11'h008, 11'h008, 1'b0);
  endtask

  task automatic t_carry();
    do_reset();
    write_per(11'h700);
    ctrl = 8'h01;
    @(negedge clk);
    chk_both("R7 carry disabled", 11'h700, 11'h700, 1'b1);
    ctrl = 8'h81;
    pulse_tick();
    chk_both("R7 carry blocked", 11'h700, 11'h700, 1'b1);
    ctrl = 8'h09;
    @(negedge clk);
    chk_both("R7 dec no carry", 11'h700, 11'h700, 1'b0);
  endtask

  task automatic t_rate();
    do_reset();
    write_per(11'h100);
    ctrl = 8'hA2;
    pulse_tick();
    chk_both("R8 first tick", 11'h140, 11'h140, 1'b0);
    pulse_tick();
    chk_both("R8 tick2", 11'h140, 11'h140, 1'b0);
    pulse_tick();
    chk_both("R8 tick3", 11'h140, 11'h140, 1'b0);
    pulse_tick();
    chk_both("R8 tick4", 11'h190, 11'h190, 1'b0);
  endtask

  initial begin
    t_reset();
    t_write();
    t_increase();
    t_decrease();
    t_gating();
    t_short();
    t_carry();
    t_rate();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule